// File: doc/BRIEF.md
# Burst Bus Master Interface

This block sits between a simple user-side request port and a pipelined, address/data-overlapped system bus. The user supplies a start address, a direction, a transfer size, a burst-length code and, for open-ended bursts, a last marker. The block then asks the arbiter for the bus and issues the beats. It labels each beat with a transfer-type code and generates the follow-on addresses of incrementing and wrapping bursts itself. It also tells the user, one pulse at a time, when the address pipeline moves, when write data must be supplied and when read data is present.

Back-pressure comes from the bus side only. The bus ready input freezes every address-phase output for as long as it stays low. Losing the grant in the middle of a burst parks the interface on IDLE. When the grant returns, the burst resumes with a fresh NONSEQ beat at the next address. The user can pause a burst on its own by raising the stall input, which inserts BUSY beats. An error response ends the burst at once and is reported to the user as a one-cycle pulse. The user request is level-held: `usr_valid` is sampled only in a cycle where `addr_req` is high and no burst is in progress.

Top module: `burst_master`

## Requirements
- R1: `addr_req` is high exactly when `bus_ready` and `bus_grant` are both high. A new burst's start address (from `usr_addr`) appears on `bus_addr` after the clock edge at which `addr_req` and `usr_valid` are both high.
- R2: `wdata_req` is high when `bus_ready` is high, the beat in the address phase is a write (transfer type NONSEQ or SEQ, `bus_write`=1) and no error is being signalled. `bus_wdata` takes `usr_wdata` at that edge, so write data trails its address by one cycle.
- R3: `rdata_valid` is high when a read beat is in its data phase, `bus_ready` is high and `bus_err` is low. `usr_rdata` always equals `bus_rdata`.
- R4: `bus_trans` uses the encoding 2'b00 IDLE, 2'b01 BUSY, 2'b10 NONSEQ and 2'b11 SEQ. The first beat of a burst is NONSEQ and later beats are SEQ. The reset value is IDLE.
- R5: `usr_burst` uses the encoding 000 single, 001 open-ended incrementing, 010/011 four-beat wrap/increment, 100/101 eight-beat wrap/increment and 110/111 sixteen-beat wrap/increment. A counted burst issues exactly that many beats. An open-ended burst ends on the beat issued while `usr_last` is high.
- R6: Each incrementing beat adds 1 << `bus_size` bytes to the address. A wrapping beat does the same inside a window of beats × bytes, keeping the address bits above the window.
- R7: While a burst is running and the grant is held, raising `usr_stall` at a ready edge issues BUSY with the address unchanged. The next beat continues from the address of the last real beat.
- R8: `usr_size` uses the encoding 0 byte, 1 halfword and 2 word. The start address is forced to alignment: bit 0 is cleared for halfwords and bits [1:0] are cleared for words.
- R9: With no request and no burst in progress, `bus_req` is low. A granted, ready cycle without a request drives IDLE.
- R10: While `bus_ready` is low, `bus_trans`, `bus_addr`, `bus_burst`, `bus_size`, `bus_write` and `bus_lock` hold their values.
- R11: `bus_lock` is set at the first beat of a multi-beat burst when `usr_lock` is high, and it drops to 0 on the burst's final beat. A lock is never raised on any beat other than a NONSEQ.
- R12: An error response (`bus_err` high with `bus_ready` high during a data phase) pulses `usr_error`. From the next cycle the interface drives IDLE, abandons the rest of the burst and lowers `bus_lock`.
- R13: A ready edge without grant drives IDLE and keeps the burst pending. The next granted beat is NONSEQ at the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| usr_valid | input | 1 | User request present |
| usr_write | input | 1 | 1 = write burst, 0 = read burst |
| usr_addr | input | AW | Burst start address |
| usr_wdata | input | DW | Write data for the beat named by `wdata_req` |
| usr_burst | input | 3 | Burst-length code (R5) |
| usr_size | input | 2 | Beat size code (R8) |
| usr_last | input | 1 | Final beat marker for open-ended bursts |
| usr_lock | input | 1 | Request a locked burst |
| usr_stall | input | 1 | Insert BUSY beat |
| addr_req | output | 1 | Address pipeline advances this edge |
| wdata_req | output | 1 | Present write data for capture this edge |
| rdata_valid | output | 1 | `usr_rdata` holds a valid read beat |
| usr_rdata | output | DW | Read data to user |
| usr_error | output | 1 | Error response pulse |
| bus_req | output | 1 | Bus request to arbiter |
| bus_grant | input | 1 | Bus grant from arbiter |
| bus_ready | input | 1 | Transfer ready from slave |
| bus_err | input | 1 | Error response from slave |
| bus_trans | output | 2 | Transfer type (R4) |
| bus_addr | output | AW | Bus address |
| bus_burst | output | 3 | Burst code on bus |
| bus_size | output | 2 | Size code on bus |
| bus_write | output | 1 | Transfer direction |
| bus_lock | output | 1 | Locked sequence |
| bus_wdata | output | DW | Write data bus |
| bus_rdata | input | DW | Read data bus |

## Verification
On every cycle, the bound checker confirms several properties. The address-phase outputs freeze while ready is low. SEQ and BUSY never follow IDLE. Issued beats are aligned. Write data lands one cycle after its request. An ungranted, unrequested or errored edge leads to IDLE. A lock rises only on a NONSEQ beat. Other behaviours can only be shown by the bench's scenarios: the exact wrapped address sequence, the beat count of each burst code, the resume address after the grant is lost, and the open-ended burst ending on the marked beat.

// File: rtl/burst_master_pkg.sv
package burst_master_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;

  // number of beats a burst code carries (open-ended returns 1, unused)
  function automatic logic [4:0] burst_beats(input logic [2:0] code);
    case (code[2:1])
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic burst_wraps(input logic [2:0] code);
    return (code[0] == 1'b0) && (code[2:1] != 2'b00);
  endfunction

  function automatic logic burst_counted(input logic [2:0] code);
    return code != BU_INCR;
  endfunction

  // low address bits that must be zero for a given size code
  function automatic logic [1:0] size_lowmask(input logic [1:0] size);
    case (size)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/burst_master_addr.sv
module burst_master_addr
  import burst_master_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [2:0]    burst,
  input  logic [1:0]    size,
  output logic [AW-1:0] nxt_addr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] step;
  logic [AW-1:0] span;
  logic [AW-1:0] mask;
  logic [AW-1:0] inc;

  always_comb begin
    step     = ONE << size;
    span     = {{(AW-5){1'b0}}, burst_beats(burst)} << size;
    mask     = span - ONE;
    inc      = cur_addr + step;
    // wrapping keeps the upper part of the window, rolls the lower part
    nxt_addr = burst_wraps(burst) ? ((cur_addr & ~mask) | (inc & mask)) : inc;
  end

endmodule

// File: rtl/burst_master_seq.sv
module burst_master_seq
  import burst_master_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          grant,
  input  logic          err_now,
  input  logic          usr_valid,
  input  logic          usr_write,
  input  logic [AW-1:0] usr_addr,
  input  logic [2:0]    usr_burst,
  input  logic [1:0]    usr_size,
  input  logic          usr_last,
  input  logic          usr_lock,
  input  logic          usr_stall,
  input  logic [AW-1:0] nxt_addr,
  output logic [1:0]    trans,
  output logic [AW-1:0] addr,
  output logic [2:0]    burst,
  output logic [1:0]    size,
  output logic          write,
  output logic          lock,
  output logic          active
);

  trans_e        trans_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    burst_q;
  logic [1:0]    size_q;
  logic          write_q;
  logic          lock_q;
  logic          active_q;
  logic          resume_q;
  logic [4:0]    cnt_q;

  logic [4:0]    beats_in;
  logic          start_last;
  logic          cont_last;
  logic [AW-1:0] start_addr;

  always_comb begin
    beats_in   = burst_beats(usr_burst);
    start_last = burst_counted(usr_burst) ? (beats_in == 5'd1) : usr_last;
    cont_last  = burst_counted(burst_q) ? (cnt_q == 5'd1) : usr_last;
    start_addr = usr_addr & ~{{(AW-2){1'b0}}, size_lowmask(usr_size)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q  <= TR_IDLE;
      addr_q   <= '0;
      burst_q  <= BU_SINGLE;
      size_q   <= '0;
      write_q  <= 1'b0;
      lock_q   <= 1'b0;
      active_q <= 1'b0;
      resume_q <= 1'b0;
      cnt_q    <= '0;
    end else if (ready) begin
      if (err_now) begin
        trans_q  <= TR_IDLE;
        active_q <= 1'b0;
        resume_q <= 1'b0;
        lock_q   <= 1'b0;
      end else if (!grant) begin
        trans_q  <= TR_IDLE;
        resume_q <= active_q;
      end else if (active_q) begin
        if (usr_stall) begin
          trans_q <= resume_q ? TR_IDLE : TR_BUSY;
        end else begin
          trans_q  <= resume_q ? TR_NSEQ : TR_SEQ;
          addr_q   <= nxt_addr;
          cnt_q    <= cnt_q - 5'd1;
          active_q <= !cont_last;
          lock_q   <= lock_q & !cont_last;
          resume_q <= 1'b0;
        end
      end else if (usr_valid) begin
        trans_q  <= TR_NSEQ;
        addr_q   <= start_addr;
        burst_q  <= usr_burst;
        size_q   <= usr_size;
        write_q  <= usr_write;
        cnt_q    <= beats_in - 5'd1;
        active_q <= !start_last;
        lock_q   <= usr_lock & !start_last;
        resume_q <= 1'b0;
      end else begin
        trans_q <= TR_IDLE;
      end
    end
  end

  assign trans  = trans_q;
  assign addr   = addr_q;
  assign burst  = burst_q;
  assign size   = size_q;
  assign write  = write_q;
  assign lock   = lock_q;
  assign active = active_q;

endmodule

// File: rtl/burst_master_dph.sv
module burst_master_dph #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          bus_err,
  input  logic [1:0]    trans,
  input  logic          write,
  input  logic [DW-1:0] usr_wdata,
  output logic          err_now,
  output logic          wdata_req,
  output logic          rdata_valid,
  output logic [DW-1:0] bus_wdata
);

  logic          dph_valid_q;
  logic          dph_write_q;
  logic [DW-1:0] wdata_q;
  logic          beat_in_addr;

  always_comb begin
    beat_in_addr = trans[1];
    err_now      = ready & bus_err & dph_valid_q;
    wdata_req    = ready & beat_in_addr & write & !err_now;
    rdata_valid  = ready & dph_valid_q & !dph_write_q & !bus_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_valid_q <= 1'b0;
      dph_write_q <= 1'b0;
      wdata_q     <= '0;
    end else if (ready) begin
      dph_valid_q <= beat_in_addr & !err_now;
      dph_write_q <= write;
      if (wdata_req) wdata_q <= usr_wdata;
    end
  end

  assign bus_wdata = wdata_q;

endmodule

// File: rtl/burst_master.sv
module burst_master
  import burst_master_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          usr_valid,
  input  logic          usr_write,
  input  logic [AW-1:0] usr_addr,
  input  logic [DW-1:0] usr_wdata,
  input  logic [2:0]    usr_burst,
  input  logic [1:0]    usr_size,
  input  logic          usr_last,
  input  logic          usr_lock,
  input  logic          usr_stall,
  output logic          addr_req,
  output logic          wdata_req,
  output logic          rdata_valid,
  output logic [DW-1:0] usr_rdata,
  output logic          usr_error,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic [1:0]    bus_trans,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_burst,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic          bus_lock,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  logic [AW-1:0] nxt_addr;
  logic          err_now;
  logic          active;

  burst_master_addr #(.AW(AW)) u_addr (
    .cur_addr (bus_addr),
    .burst    (bus_burst),
    .size     (bus_size),
    .nxt_addr (nxt_addr)
  );

  burst_master_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (bus_ready),
    .grant     (bus_grant),
    .err_now   (err_now),
    .usr_valid (usr_valid),
    .usr_write (usr_write),
    .usr_addr  (usr_addr),
    .usr_burst (usr_burst),
    .usr_size  (usr_size),
    .usr_last  (usr_last),
    .usr_lock  (usr_lock),
    .usr_stall (usr_stall),
    .nxt_addr  (nxt_addr),
    .trans     (bus_trans),
    .addr      (bus_addr),
    .burst     (bus_burst),
    .size      (bus_size),
    .write     (bus_write),
    .lock      (bus_lock),
    .active    (active)
  );

  burst_master_dph #(.DW(DW)) u_dph (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (bus_ready),
    .bus_err     (bus_err),
    .trans       (bus_trans),
    .write       (bus_write),
    .usr_wdata   (usr_wdata),
    .err_now     (err_now),
    .wdata_req   (wdata_req),
    .rdata_valid (rdata_valid),
    .bus_wdata   (bus_wdata)
  );

  assign addr_req  = bus_ready & bus_grant;
  assign bus_req   = usr_valid | active;
  assign usr_error = err_now;
  assign usr_rdata = bus_rdata;

endmodule

// File: rtl/burst_master_chk.sv
module burst_master_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ready,
  input logic          bus_grant,
  input logic [1:0]    bus_trans,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_burst,
  input logic [1:0]    bus_size,
  input logic          bus_write,
  input logic          bus_lock,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] usr_wdata,
  input logic          wdata_req,
  input logic          rdata_valid,
  input logic          usr_error
);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> ($stable(bus_trans) && $stable(bus_addr) && $stable(bus_burst)
                    && $stable(bus_size) && $stable(bus_write) && $stable(bus_lock)));

  p_seq_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == 2'b11) |-> ($past(bus_trans) != 2'b00));

  p_busy_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == 2'b01) |-> ($past(bus_trans) != 2'b00));

  p_word_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans[1] && bus_size == 2'd2) |-> (bus_addr[1:0] == 2'b00));

  p_half_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans[1] && bus_size == 2'd1) |-> (bus_addr[0] == 1'b0));

  p_wdata_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_req |=> (bus_wdata == $past(usr_wdata)));

  p_unrequested_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_grant && !bus_req) |=> (bus_trans == 2'b00));

  p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    usr_error |=> (bus_trans == 2'b00 && !bus_lock));

  p_nogrant_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && !bus_grant) |=> (bus_trans == 2'b00));

  p_lock_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> (bus_trans == 2'b10));

  p_rvalid_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> bus_ready);

endmodule

bind burst_master burst_master_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_ready   (bus_ready),
  .bus_grant   (bus_grant),
  .bus_trans   (bus_trans),
  .bus_addr    (bus_addr),
  .bus_burst   (bus_burst),
  .bus_size    (bus_size),
  .bus_write   (bus_write),
  .bus_lock    (bus_lock),
  .bus_wdata   (bus_wdata),
  .usr_wdata   (usr_wdata),
  .wdata_req   (wdata_req),
  .rdata_valid (rdata_valid),
  .usr_error   (usr_error)
);

// File: tb/tb_burst_master.sv
module tb_burst_master;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          usr_valid = 1'b0, usr_write = 1'b0, usr_last = 1'b0;
  logic          usr_lock = 1'b0, usr_stall = 1'b0;
  logic [AW-1:0] usr_addr = '0;
  logic [DW-1:0] usr_wdata = '0;
  logic [2:0]    usr_burst = '0;
  logic [1:0]    usr_size = '0;
  logic          bus_grant = 1'b0, bus_ready = 1'b1, bus_err = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          addr_req, wdata_req, rdata_valid, usr_error, bus_req;
  logic [DW-1:0] usr_rdata, bus_wdata;
  logic [1:0]    bus_trans, bus_size;
  logic [AW-1:0] bus_addr;
  logic [2:0]    bus_burst;
  logic          bus_write, bus_lock;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  burst_master #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .usr_valid(usr_valid), .usr_write(usr_write), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .usr_burst(usr_burst), .usr_size(usr_size),
    .usr_last(usr_last), .usr_lock(usr_lock), .usr_stall(usr_stall),
    .addr_req(addr_req), .wdata_req(wdata_req), .rdata_valid(rdata_valid),
    .usr_rdata(usr_rdata), .usr_error(usr_error), .bus_req(bus_req),
    .bus_grant(bus_grant), .bus_ready(bus_ready), .bus_err(bus_err),
    .bus_trans(bus_trans), .bus_addr(bus_addr), .bus_burst(bus_burst),
    .bus_size(bus_size), .bus_write(bus_write), .bus_lock(bus_lock),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        v;
    logic        w;
    logic [2:0]  bu;
    logic [1:0]  sz;
    logic [31:0] a;
    logic        st;
    logic        rdy;
    logic        gnt;
    logic        lk;
    logic [1:0]  e_tr;
    logic [31:0] e_a;
    logic        e_lk;
  } vec_t;

  // wrapping 4-beat locked word write at 0x38, then 8-beat byte read at 0x101
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b1, 3'd2, 2'd2, 32'h38,  1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 32'h38,  1'b1},
    '{1'b0, 1'b1, 3'd2, 2'd2, 32'h0,   1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 32'h3C,  1'b1},
    '{1'b0, 1'b1, 3'd2, 2'd2, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 32'h3C,  1'b1},
    '{1'b0, 1'b1, 3'd2, 2'd2, 32'h0,   1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 32'h3C,  1'b1},
    '{1'b0, 1'b1, 3'd2, 2'd2, 32'h0,   1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 32'h30,  1'b1},
    '{1'b0, 1'b1, 3'd2, 2'd2, 32'h0,   1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 32'h34,  1'b0},
    '{1'b0, 1'b1, 3'd2, 2'd2, 32'h0,   1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 32'h34,  1'b0},
    '{1'b1, 1'b0, 3'd5, 2'd0, 32'h101, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 32'h101, 1'b0},
    '{1'b0, 1'b0, 3'd5, 2'd0, 32'h0,   1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 32'h101, 1'b0},
    '{1'b0, 1'b0, 3'd5, 2'd0, 32'h0,   1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 32'h102, 1'b0},
    '{1'b0, 1'b0, 3'd5, 2'd0, 32'h0,   1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 32'h103, 1'b0},
    '{1'b0, 1'b0, 3'd5, 2'd0, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 32'h103, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    usr_valid = 1'b0; usr_stall = 1'b0; usr_last = 1'b0; usr_lock = 1'b0;
    bus_ready = 1'b1; bus_grant = 1'b1; bus_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_in();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R4 reset trans", 32'(bus_trans), 32'd0);
    check("R11 reset lock", 32'(bus_lock), 32'd0);
    check("R9 reset req", 32'(bus_req), 32'd0);
    check("R12 reset err", 32'(usr_error), 32'd0);
    check("R1 addr_req no grant", 32'(addr_req), 32'd0);
    bus_grant = 1'b1;
    #1;
    check("R1 addr_req granted", 32'(addr_req), 32'd1);

    // table walk: R4 R5 R6 R7 R10 R11 R13
    for (int i = 0; i < 12; i++) begin
      usr_valid = VEC[i].v;  usr_write = VEC[i].w;  usr_burst = VEC[i].bu;
      usr_size  = VEC[i].sz; usr_addr  = VEC[i].a;  usr_stall = VEC[i].st;
      bus_ready = VEC[i].rdy; bus_grant = VEC[i].gnt; usr_lock = VEC[i].lk;
      tick();
      check($sformatf("R4/R7/R13 row %0d trans", i), 32'(bus_trans), 32'(VEC[i].e_tr));
      check($sformatf("R6/R10 row %0d addr", i), bus_addr, VEC[i].e_a);
      check($sformatf("R11 row %0d lock", i), 32'(bus_lock), 32'(VEC[i].e_lk));
    end

    // R3 and R12: read burst hit by error
    do_reset();
    usr_valid = 1'b1; usr_write = 1'b0; usr_burst = 3'd3; usr_size = 2'd2; usr_addr = 32'h0;
    tick();
    check("R4 first beat NONSEQ", 32'(bus_trans), 32'd2);
    usr_valid = 1'b0;
    tick();
    check("R6 incr second addr", bus_addr, 32'h4);
    bus_rdata = 32'h1234_5678;
    bus_ready = 1'b0;
    #1;
    check("R3 rdata_valid ready low", 32'(rdata_valid), 32'd0);
    bus_ready = 1'b1;
    #1;
    check("R3 rdata_valid", 32'(rdata_valid), 32'd1);
    check("R3 usr_rdata", usr_rdata, 32'h1234_5678);
    bus_err = 1'b1;
    #1;
    check("R12 error pulse", 32'(usr_error), 32'd1);
    check("R3 no valid on error", 32'(rdata_valid), 32'd0);
    tick();
    bus_err = 1'b0;
    #1;
    check("R12 idle after error", 32'(bus_trans), 32'd0);
    check("R12 error one cycle", 32'(usr_error), 32'd0);
    check("R12 burst abandoned", 32'(bus_req), 32'd0);
    tick();
    check("R12 stays idle", 32'(bus_trans), 32'd0);

    // R8 alignment and R5 single beats
    usr_valid = 1'b1; usr_burst = 3'd0; usr_size = 2'd2; usr_addr = 32'h13;
    tick();
    check("R8 word align", bus_addr, 32'h10);
    usr_size = 2'd1;
    tick();
    check("R8 half align", bus_addr, 32'h12);
    check("R5 single then new NONSEQ", 32'(bus_trans), 32'd2);
    usr_valid = 1'b0;
    tick();
    check("R5 idle after single", 32'(bus_trans), 32'd0);

    // R2 write data one cycle after address
    usr_valid = 1'b1; usr_write = 1'b1; usr_burst = 3'd0; usr_size = 2'd2; usr_addr = 32'h20;
    tick();
    usr_valid = 1'b0;
    usr_wdata = 32'hA5A5_0001;
    #1;
    check("R2 wdata_req", 32'(wdata_req), 32'd1);
    tick();
    check("R2 bus_wdata", bus_wdata, 32'hA5A5_0001);
    check("R2 wdata_req low", 32'(wdata_req), 32'd0);

    // R5 open-ended burst ended by usr_last, R11 lock drop
    usr_valid = 1'b1; usr_write = 1'b1; usr_burst = 3'd1; usr_size = 2'd2;
    usr_addr = 32'h40; usr_lock = 1'b1;
    tick();
    check("R11 lock on start", 32'(bus_lock), 32'd1);
    usr_valid = 1'b0; usr_last = 1'b1;
    tick();
    check("R6 open-ended addr", bus_addr, 32'h44);
    check("R11 lock low on last", 32'(bus_lock), 32'd0);
    usr_last = 1'b0;
    tick();
    check("R5 open-ended ends", 32'(bus_trans), 32'd0);

    // R9 granted without request
    idle_in();
    tick();
    check("R9 idle when granted", 32'(bus_trans), 32'd0);
    check("R9 no request", 32'(bus_req), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule